// File: doc/BRIEF.md
# Conditional Data-Processing Execution Unit

This unit executes one 32-bit data-processing instruction per cycle. It receives the instruction word, the first source operand, and the second operand with its carry, both already produced by an external shifter. It also receives the current negative, zero, carry and overflow flags. It tests the instruction's condition code against those flags and performs one of sixteen logical or arithmetic operations. It then presents a registered result together with the destination register index, a register-write enable, the next flag values with a flag-write enable, and a request to restore the saved status word.

The condition gates everything the instruction does. When the condition fails, the instruction has no visible effect. Compare and test operations only update flags. An S-bit operation whose destination is register 15 asks for a status restore instead of writing flags. The register file, the shifter and exception entry sit outside this unit.

Top module: `dp_exec_unit`

## Requirements
- R1: The condition code is `instr[31:28]`. With flags N, Z, C and V, the codes are as follows. Codes 0 to 7 need Z, !Z, C, !C, N, !N, V and !V in turn. Code 8 needs C&!Z and code 9 needs !C|Z. Code 10 needs N==V and code 11 needs N!=V. Code 12 needs !Z&(N==V) and code 13 needs Z|(N!=V). Code 14 always passes. Code 15 never executes.
- R2: If the condition does not pass or `in_valid` is low, then `reg_we`, `flags_we` and `restore_req` are all 0 and `flags_out` equals `flags_in`.
- R3: The opcode is `instr[24:21]` and the S bit is `instr[20]`. The result for each opcode is as follows, where a is Rn and b is the shifter operand. 0: a&b. 1: a^b. 2: a-b. 3: b-a. 4: a+b. 5: a+b+C. 6: a-b-!C. 7: b-a-!C. 8: a&b. 9: a^b. 10: a-b. 11: a+b. 12: a|b. 13: b. 14: a&~b. 15: ~b.
- R4: For opcodes 4, 5 and 11 with S set, C is the carry out of the 32-bit sum and V is signed overflow.
- R5: For opcodes 2, 3, 6, 7 and 10 with S set, C is the not-borrow (1 when no borrow occurs) and V is signed overflow of the difference.
- R6: For opcodes 0, 1, 8, 9, 12, 13, 14 and 15 with S set, N is result bit 31, Z is 1 when the result is zero, C is `shf_carry`, and V is kept from `flags_in`.
- R7: Opcodes 8 to 11 never raise `reg_we`. They write flags only when S is 1. With S at 0 they have no effect.
- R8: An executed non-compare opcode with S set and `instr[15:12]`==15 raises `restore_req` and `reg_we`. It keeps `flags_we` low and passes `flags_in` through.
- R9: `flags_out` is packed {N,Z,C,V} from bit 3 down to bit 0. `rd_out` is `instr[15:12]`. `result` carries the computed value even when nothing is written.
- R10: All outputs are registered with one cycle of latency, and `out_valid` follows `in_valid`. An active-low asynchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| rn_val | input | 32 | First operand (Rn) |
| shf_val | input | 32 | Shifter operand |
| shf_carry | input | 1 | Shifter carry out |
| flags_in | input | 4 | Current {N,Z,C,V} |
| out_valid | output | 1 | Registered result valid |
| result | output | 32 | Operation result |
| rd_out | output | 4 | Destination register index |
| reg_we | output | 1 | Register-write enable |
| flags_out | output | 4 | Next {N,Z,C,V} |
| flags_we | output | 1 | Flag-write enable |
| restore_req | output | 1 | Request to restore saved status |

## Verification
The cases that are hardest to reach depend on the flags and the encoding at the same moment. One is an S-bit operation that targets register 15 while its condition passes. Others are the carry-in variants that run with C clear, and compare opcodes that have S cleared. Hand-computed vectors aim at each of these cases directly. A sweep then runs every opcode, with both values of S, over sign-boundary operand pairs and varied incoming flags. A second sweep runs all sixteen condition codes against all sixteen flag combinations.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

    typedef enum logic [3:0] {
        OP_AND   = 4'd0,
        OP_XOR   = 4'd1,
        OP_SUB   = 4'd2,
        OP_RSUB  = 4'd3,
        OP_ADD   = 4'd4,
        OP_ADDC  = 4'd5,
        OP_SUBC  = 4'd6,
        OP_RSUBC = 4'd7,
        OP_TEST  = 4'd8,
        OP_TEQV  = 4'd9,
        OP_CMPS  = 4'd10,
        OP_CMPN  = 4'd11,
        OP_OR    = 4'd12,
        OP_MOVE  = 4'd13,
        OP_CLR   = 4'd14,
        OP_NOT   = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    // Opcodes that produce no register write (flag-only group)
    function automatic logic is_compare(input alu_op_e op);
        return (op[3:2] == 2'b10);
    endfunction

    // Opcodes whose carry comes from the shifter and that keep V
    function automatic logic is_logic(input alu_op_e op);
        case (op)
            OP_AND, OP_XOR, OP_TEST, OP_TEQV,
            OP_OR, OP_MOVE, OP_CLR, OP_NOT: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dpx_cond.sv
module dpx_cond
    import dpx_pkg::*;
(
    input  logic [3:0] cond,
    input  flags_t     flg,
    output logic       pass
);
    logic ge;
    assign ge = (flg.n == flg.v);

    always_comb begin
        case (cond)
            4'd0:    pass = flg.z;
            4'd1:    pass = !flg.z;
            4'd2:    pass = flg.c;
            4'd3:    pass = !flg.c;
            4'd4:    pass = flg.n;
            4'd5:    pass = !flg.n;
            4'd6:    pass = flg.v;
            4'd7:    pass = !flg.v;
            4'd8:    pass = flg.c && !flg.z;
            4'd9:    pass = !flg.c || flg.z;
            4'd10:   pass = ge;
            4'd11:   pass = !ge;
            4'd12:   pass = !flg.z && ge;
            4'd13:   pass = flg.z || !ge;
            4'd14:   pass = 1'b1;
            default: pass = 1'b0;   // code 15: never executes
        endcase
    end
endmodule

// File: rtl/dpx_arith.sv
module dpx_arith
    import dpx_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         ovf
);
    localparam int SW = W + 1;

    logic [W-1:0]  x, y;
    logic          ci;
    logic [SW-1:0] sum;
    logic [W-1:0]  lres;

    // Operand steering for the single shared adder
    always_comb begin
        x  = a;
        y  = b;
        ci = 1'b0;
        case (op)
            OP_ADDC:          ci = cin;
            OP_SUB, OP_CMPS:  begin y = ~b; ci = 1'b1; end
            OP_SUBC:          begin y = ~b; ci = cin;  end
            OP_RSUB:          begin x = b; y = ~a; ci = 1'b1; end
            OP_RSUBC:         begin x = b; y = ~a; ci = cin;  end
            default:          ;
        endcase
    end

    assign sum = {1'b0, x} + {1'b0, y} + {{(SW-1){1'b0}}, ci};

    always_comb begin
        case (op)
            OP_AND, OP_TEST: lres = a & b;
            OP_XOR, OP_TEQV: lres = a ^ b;
            OP_OR:           lres = a | b;
            OP_MOVE:         lres = b;
            OP_CLR:          lres = a & ~b;
            default:         lres = ~b;
        endcase
    end

    assign res   = is_logic(op) ? lres : sum[W-1:0];
    assign carry = sum[W];
    assign ovf   = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
endmodule

// File: rtl/dp_exec_unit.sv
module dp_exec_unit
    import dpx_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int RIDX_W  = 4,
    parameter int PC_IDX  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] rn_val,
    input  logic [DATA_W-1:0] shf_val,
    input  logic              shf_carry,
    input  logic [3:0]        flags_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [RIDX_W-1:0] rd_out,
    output logic              reg_we,
    output logic [3:0]        flags_out,
    output logic              flags_we,
    output logic              restore_req
);
    localparam logic [RIDX_W-1:0] PC_SEL = RIDX_W'(PC_IDX);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] res;
        logic [RIDX_W-1:0] rd;
        logic              rwe;
        flags_t            flg;
        logic              fwe;
        logic              rst;
    } stage_t;

    stage_t  st_d, st_q;
    flags_t  fin;
    alu_op_e op;
    logic    sbit, pass, exec, cmp;
    logic [DATA_W-1:0] ar_res;
    logic    ar_c, ar_v;
    logic    unused_bits;

    assign fin  = flags_t'(flags_in);
    assign op   = alu_op_e'(instr[24:21]);
    assign sbit = instr[20];
    assign cmp  = is_compare(op);
    assign unused_bits = ^{instr[27:25], instr[19:16], instr[11:0]};

    dpx_cond u_cond (
        .cond (instr[31:28]),
        .flg  (fin),
        .pass (pass)
    );

    dpx_arith #(.W(DATA_W)) u_arith (
        .op    (op),
        .a     (rn_val),
        .b     (shf_val),
        .cin   (fin.c),
        .res   (ar_res),
        .carry (ar_c),
        .ovf   (ar_v)
    );

    assign exec = in_valid && pass;

    always_comb begin
        flags_t nf;
        st_d       = '0;
        st_d.valid = in_valid;
        st_d.res   = ar_res;
        st_d.rd    = instr[12 +: RIDX_W];
        st_d.rwe   = exec && !cmp;
        st_d.rst   = exec && sbit && !cmp && (instr[12 +: RIDX_W] == PC_SEL);
        st_d.fwe   = exec && sbit && !st_d.rst;

        nf   = fin;
        nf.n = ar_res[DATA_W-1];
        nf.z = (ar_res == '0);
        if (is_logic(op)) begin
            nf.c = shf_carry;
        end else begin
            nf.c = ar_c;
            nf.v = ar_v;
        end
        st_d.flg = st_d.fwe ? nf : fin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign result      = st_q.res;
    assign rd_out      = st_q.rd;
    assign reg_we      = st_q.rwe;
    assign flags_out   = st_q.flg;
    assign flags_we    = st_q.fwe;
    assign restore_req = st_q.rst;

    p_nv_inert_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:28] == 4'hF) |=> (!reg_we && !flags_we && !restore_req));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!reg_we && !flags_we && !restore_req));

    p_logic_keeps_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_logic(op)) |=> (flags_out[0] == $past(flags_in[0])));

    p_cmp_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[24:23] == 2'b10) |=> !reg_we);

    p_restore_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |-> (!flags_we && reg_we && rd_out == PC_SEL));

    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (flags_we || flags_out == $past(flags_in)));

    p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
endmodule

// File: tb/dp_exec_unit_bench.sv
`timescale 1ns/1ps
module dp_exec_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0, rn_val = '0, shf_val = '0;
    logic        shf_carry = 1'b0;
    logic [3:0]  flags_in = '0;
    logic        out_valid, reg_we, flags_we, restore_req;
    logic [31:0] result;
    logic [3:0]  rd_out, flags_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dp_exec_unit u_dp_exec_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rn_val(rn_val), .shf_val(shf_val), .shf_carry(shf_carry),
        .flags_in(flags_in), .out_valid(out_valid), .result(result),
        .rd_out(rd_out), .reg_we(reg_we), .flags_out(flags_out),
        .flags_we(flags_we), .restore_req(restore_req)
    );

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] rn;
        logic [31:0] shf;
        logic        shc;
        logic [3:0]  fin;
        logic [31:0] res;
        logic        we;
        logic        fwe;
        logic [3:0]  fo;
        logic        rs;
    } vec_t;

    // Instruction: {cond, 3'b000, opcode, S, 4'h1, rd, 12'h000}
    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{32'hE0912000, 32'hFFFFFFFF, 32'h1, 1'b0, 4'h0, 32'h0,        1'b1, 1'b1, 4'h6, 1'b0}, // R4 add carry
        '{32'hE0912000, 32'h7FFFFFFF, 32'h1, 1'b0, 4'h0, 32'h80000000, 1'b1, 1'b1, 4'h9, 1'b0}, // R4 overflow
        '{32'hE0512000, 32'h5,        32'h7, 1'b0, 4'h0, 32'hFFFFFFFE, 1'b1, 1'b1, 4'h8, 1'b0}, // R5 borrow
        '{32'hE0512000, 32'h80000000, 32'h1, 1'b0, 4'h0, 32'h7FFFFFFF, 1'b1, 1'b1, 4'h3, 1'b0}, // R5 overflow
        '{32'hE0712000, 32'h3,        32'hA, 1'b0, 4'h0, 32'h7,        1'b1, 1'b1, 4'h2, 1'b0}, // R5 reverse
        '{32'hE0B12000, 32'h1,        32'h2, 1'b0, 4'h2, 32'h4,        1'b1, 1'b1, 4'h0, 1'b0}, // R4 add with C
        '{32'hE0D12000, 32'h5,        32'h2, 1'b0, 4'h0, 32'h2,        1'b1, 1'b1, 4'h2, 1'b0}, // R5 sub C clear
        '{32'hE0F12000, 32'h2,        32'h2, 1'b0, 4'h0, 32'hFFFFFFFF, 1'b1, 1'b1, 4'h8, 1'b0}, // R5 rsub C clear
        '{32'hE0112000, 32'hF0F0F0F0, 32'h0F0F0F0F, 1'b1, 4'h1, 32'h0, 1'b1, 1'b1, 4'h7, 1'b0}, // R6 and
        '{32'hE1F12000, 32'h0,        32'h0, 1'b0, 4'h3, 32'hFFFFFFFF, 1'b1, 1'b1, 4'h9, 1'b0}, // R6 not
        '{32'hE1C12000, 32'hFF,       32'h0F, 1'b0, 4'h0, 32'hF0,      1'b1, 1'b0, 4'h0, 1'b0}, // R3 clr no S
        '{32'hE1512000, 32'h4,        32'h4, 1'b0, 4'h0, 32'h0,        1'b0, 1'b1, 4'h6, 1'b0}, // R7 cmp
        '{32'hE1112000, 32'h1,        32'h2, 1'b0, 4'h6, 32'h0,        1'b0, 1'b1, 4'h4, 1'b0}, // R7 test
        '{32'h00912000, 32'h1,        32'h2, 1'b0, 4'h0, 32'h3,        1'b0, 1'b0, 4'h0, 1'b0}, // R2 EQ fail
        '{32'h11A12000, 32'h0,        32'h12345678, 1'b0, 4'h0, 32'h12345678, 1'b1, 1'b0, 4'h0, 1'b0}, // R1 NE
        '{32'hF1B12000, 32'h0,        32'h5, 1'b0, 4'hF, 32'h5,        1'b0, 1'b0, 4'hF, 1'b0}, // R1 code 15
        '{32'hE1B1F000, 32'h0,        32'h0, 1'b0, 4'h2, 32'h0,        1'b1, 1'b0, 4'h2, 1'b1}, // R8 restore
        '{32'hC0212000, 32'hFF,       32'h0F, 1'b0, 4'h9, 32'hF0,      1'b1, 1'b0, 4'h9, 1'b0}, // R1 GT
        '{32'hD0812000, 32'h1,        32'h1, 1'b0, 4'h8, 32'h2,        1'b1, 1'b0, 4'h8, 1'b0}, // R1 LE
        '{32'h80812000, 32'h1,        32'h1, 1'b0, 4'h6, 32'h2,        1'b0, 1'b0, 4'h6, 1'b0}, // R2 HI fail
        '{32'hE1412000, 32'h4,        32'h4, 1'b0, 4'h0, 32'h0,        1'b0, 1'b0, 4'h0, 1'b0}  // R7 cmp no S
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                         input logic sc, input logic [3:0] f);
        @(negedge clk);
        in_valid = 1'b1; instr = ins; rn_val = a; shf_val = b; shf_carry = sc; flags_in = f;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic ref_cond(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            0: return z;          1: return !z;
            2: return cy;         3: return !cy;
            4: return n;          5: return !n;
            6: return v;          7: return !v;
            8: return cy & !z;    9: return !cy | z;
            10: return n == v;    11: return n != v;
            12: return !z & (n == v);
            13: return z | (n != v);
            14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Reference model from R1..R9; returns {res, we, fwe, flags, restore}
    function automatic logic [38:0] ref_model(input logic [31:0] ins, input logic [31:0] a,
            input logic [31:0] b, input logic sc, input logic [3:0] f);
        logic [3:0] op; logic s, ex, lg, cmpop, we, fwe, rs, cy, v;
        logic [31:0] r;
        longint ua, ub, sa, sb, t, sv;
        int ci;
        op = ins[24:21]; s = ins[20];
        ex = ref_cond(ins[31:28], f);
        ci = int'(f[1]);
        ua = longint'({32'b0, a}); ub = longint'({32'b0, b});
        sa = longint'($signed(a)); sb = longint'($signed(b));
        lg = 1'b0; cy = 1'b0; v = 1'b0; r = '0;
        case (op)
            0, 8:  begin r = a & b;  lg = 1'b1; end
            1, 9:  begin r = a ^ b;  lg = 1'b1; end
            12:    begin r = a | b;  lg = 1'b1; end
            13:    begin r = b;      lg = 1'b1; end
            14:    begin r = a & ~b; lg = 1'b1; end
            15:    begin r = ~b;     lg = 1'b1; end
            4, 11, 5: begin
                t  = ua + ub + ((op == 5) ? ci : 0);
                sv = sa + sb + ((op == 5) ? ci : 0);
                r = t[31:0]; cy = (t >= 64'sh1_0000_0000);
                v = (sv > 64'sh7FFF_FFFF) || (sv < -64'sh8000_0000);
            end
            2, 10, 6: begin
                t  = ua - ub - ((op == 6) ? (1 - ci) : 0);
                sv = sa - sb - ((op == 6) ? (1 - ci) : 0);
                r = t[31:0]; cy = (t >= 0);
                v = (sv > 64'sh7FFF_FFFF) || (sv < -64'sh8000_0000);
            end
            default: begin // 3, 7
                t  = ub - ua - ((op == 7) ? (1 - ci) : 0);
                sv = sb - sa - ((op == 7) ? (1 - ci) : 0);
                r = t[31:0]; cy = (t >= 0);
                v = (sv > 64'sh7FFF_FFFF) || (sv < -64'sh8000_0000);
            end
        endcase
        cmpop = (op >= 8 && op <= 11);
        we  = ex && !cmpop;
        rs  = ex && s && !cmpop && ins[15:12] == 4'd15;
        fwe = ex && s && !rs;
        if (!fwe)     return {r, we, fwe, f, rs};
        else if (lg)  return {r, we, fwe, r[31], r == 0, sc, f[0], rs};
        else          return {r, we, fwe, r[31], r == 0, cy, v, rs};
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [38:0] e;
        // R10: reset holds outputs at zero even with an instruction presented
        in_valid = 1'b1; instr = 32'hE0912000; rn_val = 32'h1; shf_val = 32'h1; flags_in = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset valid", {31'b0, out_valid}, 32'h0);
        check("R10 reset result", result, 32'h0);
        check("R10 reset enables", {29'b0, reg_we, flags_we, restore_req}, 32'h0);
        check("R10 reset flags", {28'b0, flags_out}, 32'h0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].ins, VECS[i].rn, VECS[i].shf, VECS[i].shc, VECS[i].fin);
            check($sformatf("R10 vec%0d valid", i), {31'b0, out_valid}, 32'h1);
            check($sformatf("R3 vec%0d result", i), result, VECS[i].res);
            check($sformatf("R9 vec%0d rd", i), {28'b0, rd_out}, {28'b0, VECS[i].ins[15:12]});
            check($sformatf("R7 vec%0d reg_we", i), {31'b0, reg_we}, {31'b0, VECS[i].we});
            check($sformatf("R2 vec%0d flags_we", i), {31'b0, flags_we}, {31'b0, VECS[i].fwe});
            check($sformatf("R6 vec%0d flags", i), {28'b0, flags_out}, {28'b0, VECS[i].fo});
            check($sformatf("R8 vec%0d restore", i), {31'b0, restore_req}, {31'b0, VECS[i].rs});
        end

        // Sweep every opcode, both S values, against the reference model
        for (int op = 0; op < 16; op++) begin
            for (int s = 0; s < 2; s++) begin
                for (int k = 0; k < 6; k++) begin
                    logic [31:0] a, b, ins;
                    logic [3:0] f, rd;
                    case (k)
                        0: begin a = 32'h0;        b = 32'h0;        end
                        1: begin a = 32'h7FFFFFFF; b = 32'h7FFFFFFF; end
                        2: begin a = 32'h80000000; b = 32'h80000000; end
                        3: begin a = 32'hFFFFFFFF; b = 32'h00000001; end
                        4: begin a = 32'h12345678; b = 32'h9ABCDEF0; end
                        default: begin a = 32'h00000003; b = 32'h00000005; end
                    endcase
                    f   = 4'(op * 3 + k + s * 5);
                    rd  = (k == 5) ? 4'd15 : 4'(k + 1);
                    ins = {4'hE, 3'b000, 4'(op), 1'(s), 4'h1, rd, 12'h000};
                    drive(ins, a, b, 1'(k), f);
                    e = ref_model(ins, a, b, 1'(k), f);
                    check($sformatf("R3 op%0d s%0d k%0d result", op, s, k), result, e[38:7]);
                    check($sformatf("R4 R5 op%0d s%0d k%0d flags", op, s, k), {28'b0, flags_out}, {28'b0, e[4:1]});
                    check($sformatf("R7 R8 op%0d s%0d k%0d en", op, s, k),
                          {29'b0, reg_we, flags_we, restore_req}, {29'b0, e[6], e[5], e[0]});
                end
            end
        end

        // Sweep all conditions against all flag combinations (R1)
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                drive({4'(c), 3'b000, 4'd13, 1'b0, 4'h1, 4'h2, 12'h0}, 32'h0, 32'hA5A5A5A5, 1'b0, 4'(f));
                check($sformatf("R1 cond%0d flags%0h", c, f), {31'b0, reg_we},
                      {31'b0, ref_cond(4'(c), 4'(f))});
            end
        end

        // R2 R10: idle input gives no effects
        @(negedge clk);
        in_valid = 1'b0; instr = 32'hE0912000;
        @(posedge clk);
        @(negedge clk);
        check("R10 idle valid", {31'b0, out_valid}, 32'h0);
        check("R2 idle enables", {29'b0, reg_we, flags_we, restore_req}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule